// File: doc/BRIEF.md
# Interrupt Flush Controller for an Eight-Stage Pipeline

This block is the control side of an eight-stage in-order instruction pipeline (two fetch stages, two decode stages, two operand-read stages, execute, write-back) and decides how that pipeline reacts to interrupts. Each stage holds a valid bit and the address of the instruction it carries; instructions are opaque tokens and the fetch stream is sequential. An instruction that has reached the second decode stage is committed and always runs to completion. When an interrupt is accepted, everything younger than that point is discarded. The committed work drains, and fetch is redirected to the service routine after a fixed number of cycles.

Requests are latched in a pending register, and the lowest-numbered one wins whenever the controller is free to accept. The address to resume at is pushed on a small stack when an interrupt is accepted. A return pulse pops it and restarts fetch at the first fetch stage from that address. While a routine is in service, further requests wait unless nesting is enabled, so the timing of each service stays fixed once it has begun. There is no cache and no variable-latency fetch path, so entry latency never depends on memory state.

Top module: `irq_flush_ctl`

## Requirements
- R1: While `rst_n` is low (synchronous, active low) `irq_ack`, `fetch_redirect`, `in_service` and `retire_valid` are 0. After release the first fetched address is 0x0100 and it retires 8 cycles later.
- R2: With no interrupt activity, one instruction retires per cycle on `retire_valid`/`retire_addr`, at consecutive addresses.
- R3: A request bit held on `irq_req` for a single cycle is latched. When the controller is free, `irq_ack` pulses for exactly one cycle, two cycles after the request was presented, with the line number on `ack_id`.
- R4: When several requests are pending at once, the lowest-numbered line is acknowledged first. The others stay pending.
- R5: Instructions in the second decode stage or later when a request is accepted complete. In steady flow that is four further retirements: in the `irq_ack` cycle and the three after it, at addresses that continue the sequence.
- R6: Instructions in the first three stages when a request is accepted never retire. No instruction retires from the cycle of the entry redirect until the first instruction of the service routine retires, 7 cycles after that redirect.
- R7: `fetch_redirect` pulses exactly 4 cycles after `irq_ack`, whatever the pipeline holds. `redirect_addr` is `irq_vector + 16*ack_id`, with `irq_vector` sampled in the cycle of acceptance.
- R8: A `ret_pulse` while a routine is in service gives a `fetch_redirect` in the next cycle to the saved resume address, and that instruction retires 7 cycles later. The saved address is that of the oldest discarded instruction; if no instruction was in the first three stages, it is the address after the youngest committed instruction.
- R9: With `nest_enable` low, no request is acknowledged while `in_service` is high. A request that arrived during service is acknowledged in the cycle after the return redirect.
- R10: With `nest_enable` high, a request is acknowledged during service (not during the drain) up to a nesting depth of 4. Returns restore resume addresses in last-in first-out order.
- R11: A `ret_pulse` while no routine is in service, or while the entry drain is still running, is ignored. It causes no redirect and no change to the retire sequence.
- R12: `in_service` rises in the `irq_ack` cycle and falls in the cycle of the redirect caused by the outermost return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 8 | Interrupt request lines, one bit per line |
| irq_vector | input | 16 | Base address of the service routines |
| nest_enable | input | 1 | Allows acceptance of a request during service |
| ret_pulse | input | 1 | Return from the current service routine |
| irq_ack | output | 1 | One-cycle pulse when a request is accepted |
| ack_id | output | 3 | Line number of the accepted request |
| fetch_redirect | output | 1 | One-cycle pulse when fetch restarts at a new address |
| redirect_addr | output | 16 | Address at which fetch restarts |
| in_service | output | 1 | At least one service routine is active |
| retire_valid | output | 1 | An instruction leaves the write-back stage |
| retire_addr | output | 16 | Address of the retiring instruction |

## Verification
Two functions can fall in the same cycle: a return and a request that became pending while a routine was in service. The bench provokes this by raising a lower-numbered line during a service routine with nesting off, then pulsing the return. It expects the return redirect in one cycle and the acknowledge in the very next. It also expects the second entry to save the resume address of the first return, because that refetched instruction is still in a fetch stage when it is discarded. A return pulse placed inside the entry drain is also judged: the redirect must still come 4 cycles after the acknowledge and go to the service routine.

// File: rtl/ifc_pkg.sv
// Package: shared types of the interrupt flush controller.
// Assumes: nothing beyond IEEE 1800-2017.
package ifc_pkg;

    // Controller phases: normal flow, entry drain, inside a service routine.
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_SERVICE = 2'd2
    } ctl_state_e;

endpackage

// File: rtl/ifc_pending.sv
// Module: ifc_pending
// Latches interrupt request bits and offers the lowest-numbered pending one.
// Assumes: take is asserted only while any_pend is high; a request arriving
// in the cycle its own line is taken stays pending.
module ifc_pending #(
    parameter int NIRQ = 8,
    parameter int IDW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] req,
    input  logic            take,
    output logic            any_pend,
    output logic [IDW-1:0]  pick_id
);

    logic [NIRQ-1:0] pend;
    logic [NIRQ-1:0] clr;

    // Purpose: choose the lowest-numbered pending line.
    always_comb begin
        pick_id = '0;
        for (int i = NIRQ - 1; i >= 0; i--) begin
            if (pend[i]) pick_id = IDW'(i);
        end
    end

    // Purpose: form the clear mask for the line being taken.
    always_comb begin
        for (int i = 0; i < NIRQ; i++) begin
            clr[i] = take && (IDW'(i) == pick_id);
        end
    end

    // Purpose: hold pending requests until they are accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | req;
    end

    assign any_pend = |pend;

endmodule

// File: rtl/ifc_pipe.sv
// Module: ifc_pipe
// Valid bits and address tags of an in-order pipeline that advances every
// cycle. A flush clears the stages before the commit stage and stops the
// youngest pre-commit entry from entering it. Also computes the resume
// address to save if a flush happens now.
// Assumes: tags are not reset; only valid bits carry meaning after reset.
module ifc_pipe #(
    parameter int STAGES = 8,
    parameter int COMMIT = 3,
    parameter int AW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_en,
    input  logic [AW-1:0] fetch_addr,
    input  logic          flush,
    output logic          retire_valid,
    output logic [AW-1:0] retire_addr,
    output logic [AW-1:0] resume_addr
);

    logic          vld [STAGES];
    logic [AW-1:0] tag [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                // Purpose: load the first fetch stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) vld[0] <= 1'b0;
                    else        vld[0] <= fetch_en;
                end
                // Purpose: capture the fetched address.
                always_ff @(posedge clk) begin
                    if (fetch_en) tag[0] <= fetch_addr;
                end
            end else begin : g_body
                localparam bit KILLABLE = (g <= COMMIT);
                // Purpose: advance the valid bit, dropping it on a flush.
                always_ff @(posedge clk) begin
                    if (!rst_n) vld[g] <= 1'b0;
                    else        vld[g] <= vld[g-1] && !(flush && KILLABLE);
                end
                // Purpose: advance the address tag.
                always_ff @(posedge clk) begin
                    tag[g] <= tag[g-1];
                end
            end
        end
    endgenerate

    // Purpose: oldest pre-commit entry, else successor of youngest committed.
    always_comb begin
        resume_addr = fetch_addr;
        for (int i = STAGES - 1; i >= COMMIT; i--) begin
            if (vld[i]) resume_addr = tag[i] + AW'(1);
        end
        for (int i = 0; i < COMMIT; i++) begin
            if (vld[i]) resume_addr = tag[i];
        end
    end

    assign retire_valid = vld[STAGES-1];
    assign retire_addr  = tag[STAGES-1];

endmodule

// File: rtl/ifc_resume_stack.sv
// Module: ifc_resume_stack
// Last-in first-out store of resume addresses, one slot per nesting level.
// Assumes: push is never asserted when full, pop never when empty, and the
// two are never asserted together.
module ifc_resume_stack #(
    parameter int DEPTH = 4,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top,
    output logic          nonempty,
    output logic          full,
    output logic          single
);

    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] level;
    logic [AW-1:0] slot [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            // Purpose: write this slot when it is the next free one.
            always_ff @(posedge clk) begin
                if (push && level == LW'(g)) slot[g] <= din;
            end
        end
    endgenerate

    // Purpose: track the number of stored addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)    level <= '0;
        else if (push) level <= level + LW'(1);
        else if (pop)  level <= level - LW'(1);
    end

    // Purpose: present the most recently pushed address.
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (LW'(i + 1) == level) top = slot[i];
        end
    end

    assign nonempty = (level != '0);
    assign full     = (level == LW'(DEPTH));
    assign single   = (level == LW'(1));

endmodule

// File: rtl/irq_flush_ctl.sv
// Module: irq_flush_ctl (top)
// Interrupt response of an eight-stage in-order pipeline: accept a pending
// request, discard the stages before the commit point, let committed work
// drain for a fixed count, redirect fetch to the service routine, and on
// return refetch from the saved resume address.
// Assumes: fetch is sequential, one instruction per cycle, no stalls;
// service routine entry = irq_vector + VEC_STRIDE * line.
module irq_flush_ctl
    import ifc_pkg::*;
#(
    parameter int NIRQ         = 8,
    parameter int AW           = 16,
    parameter int NEST_DEPTH   = 4,
    parameter int VEC_STRIDE   = 16,
    parameter int unsigned RESET_ADDR = 32'h0100,
    parameter int IDW          = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [AW-1:0]   irq_vector,
    input  logic            nest_enable,
    input  logic            ret_pulse,
    output logic            irq_ack,
    output logic [IDW-1:0]  ack_id,
    output logic            fetch_redirect,
    output logic [AW-1:0]   redirect_addr,
    output logic            in_service,
    output logic            retire_valid,
    output logic [AW-1:0]   retire_addr
);

    localparam int STAGES    = 8;
    localparam int COMMIT    = 3;
    localparam int DRAIN_LEN = STAGES - COMMIT - 1;
    localparam int CW        = $clog2(DRAIN_LEN + 1);

    ctl_state_e    state;
    logic [CW-1:0] cnt;
    logic [AW-1:0] pc;
    logic [AW-1:0] isr_addr;

    logic           any_pend;
    logic [IDW-1:0] pick_id;
    logic           take, do_ret, drain_done, flush;
    logic           fetch_en;
    logic [AW-1:0]  fetch_addr;
    logic [AW-1:0]  resume_addr;
    logic [AW-1:0]  stk_top;
    logic           stk_nonempty, stk_full, stk_single;

    // Purpose: decide acceptance, return and end of drain for this cycle.
    always_comb begin
        do_ret     = (state == ST_SERVICE) && ret_pulse;
        drain_done = (state == ST_DRAIN) && (cnt == '0);
        take       = any_pend && !do_ret &&
                     ((state == ST_RUN) ||
                      ((state == ST_SERVICE) && nest_enable && !stk_full));
        flush      = take || do_ret;
    end

    // Purpose: choose what, if anything, enters the first fetch stage.
    always_comb begin
        fetch_en = !take && ((state != ST_DRAIN) || drain_done);
        if (drain_done)  fetch_addr = isr_addr;
        else if (do_ret) fetch_addr = stk_top;
        else             fetch_addr = pc;
    end

    // Purpose: sequence run, drain and service phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
            cnt   <= '0;
        end else begin
            case (state)
                ST_RUN: if (take) begin
                    state <= ST_DRAIN;
                    cnt   <= CW'(DRAIN_LEN - 1);
                end
                ST_DRAIN: begin
                    if (drain_done) state <= ST_SERVICE;
                    else            cnt   <= cnt - CW'(1);
                end
                ST_SERVICE: begin
                    if (do_ret && stk_single) state <= ST_RUN;
                    else if (take) begin
                        state <= ST_DRAIN;
                        cnt   <= CW'(DRAIN_LEN - 1);
                    end
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    // Purpose: keep the next sequential fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= AW'(RESET_ADDR);
        else if (fetch_en) pc <= fetch_addr + AW'(1);
    end

    // Purpose: capture the routine entry address at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)    isr_addr <= '0;
        else if (take) isr_addr <= irq_vector + AW'(pick_id) * AW'(VEC_STRIDE);
    end

    // Purpose: register the acknowledge and redirect outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_ack        <= 1'b0;
            ack_id         <= '0;
            fetch_redirect <= 1'b0;
            redirect_addr  <= '0;
        end else begin
            irq_ack        <= take;
            fetch_redirect <= drain_done || do_ret;
            if (take) ack_id <= pick_id;
            if (drain_done || do_ret) redirect_addr <= fetch_addr;
        end
    end

    ifc_pending #(.NIRQ(NIRQ), .IDW(IDW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (irq_req),
        .take     (take),
        .any_pend (any_pend),
        .pick_id  (pick_id)
    );

    ifc_pipe #(.STAGES(STAGES), .COMMIT(COMMIT), .AW(AW)) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_en     (fetch_en),
        .fetch_addr   (fetch_addr),
        .flush        (flush),
        .retire_valid (retire_valid),
        .retire_addr  (retire_addr),
        .resume_addr  (resume_addr)
    );

    ifc_resume_stack #(.DEPTH(NEST_DEPTH), .AW(AW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (do_ret),
        .din      (resume_addr),
        .top      (stk_top),
        .nonempty (stk_nonempty),
        .full     (stk_full),
        .single   (stk_single)
    );

    assign in_service = stk_nonempty;

endmodule

// File: rtl/ifc_checker.sv
// Module: ifc_checker
// Temporal properties on the ports of irq_flush_ctl, attached by bind.
// Assumes: the entry drain length of the default eight-stage pipeline (4).
module ifc_checker (
    input logic clk,
    input logic rst_n,
    input logic irq_ack,
    input logic fetch_redirect,
    input logic in_service,
    input logic ret_pulse,
    input logic nest_enable
);

    // R3: an acknowledge lasts one cycle
    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R7: fixed entry latency from acknowledge to redirect
    p_entry_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> ##4 fetch_redirect);

    // R7: acceptance and redirect never coincide
    p_ack_excl_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> !fetch_redirect);

    // R9: no acceptance while serving with nesting off
    p_hold_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_service && !nest_enable) |=> !irq_ack);

    // R11: a return outside service does nothing
    p_ret_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_service && ret_pulse) |=> !fetch_redirect);

    // R12: service flag is up whenever a request is acknowledged
    p_service_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> in_service);

endmodule

bind irq_flush_ctl ifc_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .irq_ack        (irq_ack),
    .fetch_redirect (fetch_redirect),
    .in_service     (in_service),
    .ret_pulse      (ret_pulse),
    .nest_enable    (nest_enable)
);

// File: tb/irq_flush_ctl_test.sv
`timescale 1ns/100ps
// Bench: irq_flush_ctl_test
// Directed corner cases plus seeded random entries and returns; expected
// values come from bench functions derived from the requirements.
module irq_flush_ctl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_req = '0;
    logic [15:0] irq_vector = '0;
    logic        nest_enable = 1'b0;
    logic        ret_pulse = 1'b0;
    logic        irq_ack;
    logic [2:0]  ack_id;
    logic        fetch_redirect;
    logic [15:0] redirect_addr;
    logic        in_service;
    logic        retire_valid;
    logic [15:0] retire_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [15:0] last_ret = '0;
    logic [15:0] pre_ack  = '0;

    always #2.5 clk = ~clk;

    irq_flush_ctl uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .irq_req        (irq_req),
        .irq_vector     (irq_vector),
        .nest_enable    (nest_enable),
        .ret_pulse      (ret_pulse),
        .irq_ack        (irq_ack),
        .ack_id         (ack_id),
        .fetch_redirect (fetch_redirect),
        .redirect_addr  (redirect_addr),
        .in_service     (in_service),
        .retire_valid   (retire_valid),
        .retire_addr    (retire_addr)
    );

    function automatic logic [15:0] isr_of(input int id, input logic [15:0] vec);
        return vec + 16'(id * 16);
    endfunction

    function automatic int lowest(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // advance one clock and settle just after the edge
    task automatic tick();
        @(posedge clk);
        #1;
        if (retire_valid) last_ret = retire_addr;
    endtask

    // present a request mask for one cycle and expect its acknowledge
    task automatic req_and_ack(input logic [7:0] mask, input logic [15:0] vec);
        irq_vector = vec;
        irq_req = mask;
        tick();
        irq_req = '0;
        chk(!irq_ack, "R3", "ack too early", irq_ack, 0);
        pre_ack = last_ret;
        tick();
        chk(irq_ack, "R3", "ack missing", irq_ack, 1);
        chk(int'(ack_id) == lowest(mask), "R4", "ack_id", ack_id, lowest(mask));
        chk(in_service, "R12", "in_service at ack", in_service, 1);
    endtask

    // from the ack cycle: drain, entry redirect, first routine retire
    task automatic after_ack(input int id, input logic [15:0] vec, input bit drain_chk,
                             input bit ret_in_drain, output logic [15:0] resume);
        logic [15:0] p;
        p = pre_ack;
        for (int j = 0; j < 4; j++) begin
            if (j > 0) tick();
            if (j == 0 && ret_in_drain) ret_pulse = 1'b1;
            if (j == 1) ret_pulse = 1'b0;
            if (drain_chk) begin
                chk(retire_valid && retire_addr == p + 16'd1, "R5", "drain retire",
                    retire_addr, p + 16'd1);
                p = retire_addr;
            end
            if (j > 0) chk(!fetch_redirect, "R11", "early redirect", fetch_redirect, 0);
        end
        resume = p + 16'd1;
        tick();
        chk(fetch_redirect && redirect_addr == isr_of(id, vec), "R7", "entry redirect",
            redirect_addr, isr_of(id, vec));
        chk(!retire_valid, "R6", "flushed retire", retire_valid, 0);
        for (int j = 0; j < 6; j++) begin
            tick();
            chk(!retire_valid, "R6", "flushed retire", retire_valid, 0);
        end
        tick();
        chk(retire_valid && retire_addr == isr_of(id, vec), "R6", "first routine retire",
            retire_addr, isr_of(id, vec));
    endtask

    // pulse the return and check the redirect and the refetched retire
    task automatic leave(input logic [15:0] exp, input bit still_in);
        ret_pulse = 1'b1;
        tick();
        ret_pulse = 1'b0;
        chk(fetch_redirect && redirect_addr == exp, "R8", "return redirect",
            redirect_addr, exp);
        chk(in_service == still_in, "R12", "in_service after return", in_service, still_in);
        for (int j = 0; j < 6; j++) tick();
        tick();
        chk(retire_valid && retire_addr == exp, "R8", "resume retire", retire_addr, exp);
    endtask

    task automatic run_idle(input int n);
        logic [15:0] p;
        p = last_ret;
        for (int j = 0; j < n; j++) begin
            tick();
            chk(retire_valid && retire_addr == p + 16'd1, "R2", "sequential retire",
                retire_addr, p + 16'd1);
            p = retire_addr;
        end
    endtask

    initial begin
        logic [15:0] res_main, res_in;
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) tick();
        chk(!irq_ack && !fetch_redirect && !in_service && !retire_valid, "R1",
            "outputs in reset", {irq_ack, fetch_redirect, in_service, retire_valid}, 0);
        rst_n = 1'b1;
        for (int j = 0; j < 7; j++) tick();
        chk(!retire_valid, "R1", "retire before fill", retire_valid, 0);
        tick();
        chk(retire_valid && retire_addr == 16'h0100, "R1", "first retire", retire_addr, 16'h0100);
        run_idle(10);

        // R3 R5 R6 R7 R8: plain entry and return
        req_and_ack(8'h10, 16'h4000);
        after_ack(4, 16'h4000, 1'b1, 1'b0, res_main);
        leave(res_main, 1'b0);
        run_idle(4);

        // R11: return outside service is ignored
        ret_pulse = 1'b1;
        tick();
        ret_pulse = 1'b0;
        chk(!fetch_redirect && !in_service, "R11", "stray return",
            fetch_redirect, 0);
        run_idle(8);

        // R11: return during the entry drain is ignored
        req_and_ack(8'h20, 16'h5000);
        after_ack(5, 16'h5000, 1'b1, 1'b1, res_main);
        leave(res_main, 1'b0);
        run_idle(4);

        // R4: simultaneous requests, lowest first; the other follows the return
        req_and_ack(8'h06, 16'h6000);
        after_ack(1, 16'h6000, 1'b1, 1'b0, res_main);
        ret_pulse = 1'b1;
        tick();
        ret_pulse = 1'b0;
        chk(fetch_redirect && redirect_addr == res_main, "R8", "return redirect",
            redirect_addr, res_main);
        tick();
        chk(irq_ack && ack_id == 3'd2, "R4", "second line after return", ack_id, 2);
        after_ack(2, 16'h6000, 1'b0, 1'b0, res_in);
        leave(res_main, 1'b0);
        run_idle(4);

        // R9: request during service waits; return and ack in adjacent cycles
        req_and_ack(8'h08, 16'h7000);
        after_ack(3, 16'h7000, 1'b1, 1'b0, res_main);
        irq_req = 8'h01;
        tick();
        irq_req = '0;
        for (int j = 0; j < 8; j++) begin
            tick();
            chk(!irq_ack, "R9", "ack during service", irq_ack, 0);
        end
        ret_pulse = 1'b1;
        tick();
        ret_pulse = 1'b0;
        chk(fetch_redirect && redirect_addr == res_main, "R9", "return before ack",
            redirect_addr, res_main);
        tick();
        chk(irq_ack && ack_id == 3'd0, "R9", "held request taken", irq_ack, 1);
        after_ack(0, 16'h7000, 1'b0, 1'b0, res_in);
        leave(res_main, 1'b0);
        run_idle(4);

        // R10: nested entry and last-in first-out returns
        nest_enable = 1'b1;
        req_and_ack(8'h08, 16'h8000);
        after_ack(3, 16'h8000, 1'b1, 1'b0, res_main);
        run_idle(3);
        req_and_ack(8'h02, 16'h9000);
        after_ack(1, 16'h9000, 1'b1, 1'b0, res_in);
        run_idle(3);
        chk(in_service, "R10", "nested in_service", in_service, 1);
        leave(res_in, 1'b1);
        run_idle(3);
        leave(res_main, 1'b0);
        nest_enable = 1'b0;
        run_idle(4);

        // R7 R8: seeded random entries
        for (int it = 0; it < 20; it++) begin
            int id;
            logic [15:0] vec;
            id  = $urandom_range(0, 7);
            vec = 16'($urandom_range(1, 14)) << 12;
            req_and_ack(8'(1 << id), vec);
            after_ack(id, vec, 1'b1, 1'b0, res_main);
            run_idle($urandom_range(0, 10));
            leave(res_main, 1'b0);
            run_idle($urandom_range(2, 8));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule